// File: doc/BRIEF.md
# Extended-Precision Value Classifier

This block sorts a single 80-bit extended-precision register value into one of seven classes and reports the class on four condition bits, C3, C2, C1 and C0. The seven classes are empty, zero, denormal, normal, infinity, NaN and unsupported encoding. The caller supplies the value, the tag that marks the register as empty, and a one-cycle start strobe. One clock later the block raises a one-cycle valid strobe and updates the condition bits.

The block only classifies. It raises no exception, and it does not read, pop or otherwise change any register stack. Fetching the value from the stack is left to the caller. The value layout is fixed: the sign is bit 79, the biased exponent is bits 78:64 and the significand is bits 63:0. Bit 63 of the significand is the explicit integer bit.

Top module: `xcls_top`

## Requirements
- R1: While reset is held and after its release, `valid_o` is 0 and `cc_o` is 4'b0000 until the first start strobe is captured.
- R2: A start strobe sampled at a clock edge makes `valid_o` 1 for exactly the following cycle and updates `cc_o` at the same edge. When no strobe is sampled, `valid_o` is 0 and `cc_o` keeps its value whatever the other inputs do. Strobes on consecutive cycles each give their own result.
- R3: When the empty tag is set, the code is C3=1, C2=0, C0=1 whatever the value bits hold. `cc_o` bit 3 is C3, bit 2 is C2, bit 1 is C1 and bit 0 is C0.
- R4: A value with exponent 0 and significand 0 is a zero: C3=1, C2=0, C0=0.
- R5: A value with exponent 0 and a nonzero significand is a denormal: C3=1, C2=1, C0=0. This includes a significand whose only set bit is the integer bit.
- R6: A value whose exponent is neither 0 nor all ones, with the integer bit (bit 63) set, is a normal: C3=0, C2=1, C0=0.
- R7: A value with an all-ones exponent and significand exactly 0x8000_0000_0000_0000 is an infinity: C3=0, C2=1, C0=1.
- R8: A value with an all-ones exponent, the integer bit set and a nonzero fraction (bits 62:0), quiet or signaling, is a NaN: C3=0, C2=0, C0=1.
- R9: A value with a nonzero exponent and the integer bit clear is an unsupported encoding: C3=0, C2=0, C0=0. Both the all-ones exponent and the ordinary exponents are covered.
- R10: C1 equals the sign bit (bit 79) of the value for every class, including an empty register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Classify the value presented in this cycle |
| empty_i | input | 1 | Register tag marks the value as empty |
| value_i | input | 80 | Extended-precision value: sign, exponent, significand |
| valid_o | output | 1 | One-cycle pulse when `cc_o` holds a new result |
| cc_o | output | 4 | Condition bits {C3, C2, C1, C0} |

## Verification
The bench targets the encodings at the edges between classes, and runs each of them with both signs.

- **Pseudo-denormal.** This is a zero exponent with only the integer bit set. A design that tests the integer bit before the exponent reports it as normal.
- **Pseudo-infinity and pseudo-NaN.** These have an all-ones exponent and a clear integer bit. A design that decodes them as infinity or NaN gives C0=1 where 0 is expected.
- **Unnormal.** This is an ordinary exponent with a clear integer bit. A design that trusts the exponent alone reports it as normal.
- **Signaling NaN.** This has only the lowest fraction bit set. A design that checks only the top fraction bit calls it an infinity.
- **Empty register.** An empty register with NaN bits in its value must still report empty, and must still copy the sign into C1.

The bench also checks that the result holds between strobes and that back-to-back strobes each produce their own result.

// File: rtl/xcls_pkg.sv
package xcls_pkg;

  typedef enum logic [2:0] {
    CL_EMPTY  = 3'd0,
    CL_ZERO   = 3'd1,
    CL_DENORM = 3'd2,
    CL_NORMAL = 3'd3,
    CL_INF    = 3'd4,
    CL_NAN    = 3'd5,
    CL_UNSUP  = 3'd6
  } xcls_kind_e;

  // one flag per class; exactly one is set for any input
  typedef struct packed {
    logic empty;
    logic zero;
    logic denorm;
    logic normal;
    logic inf;
    logic nan;
    logic unsup;
  } xcls_flags_t;

  // class to {C3, C2, C0}; C1 is the sign and is added by the caller
  function automatic logic [2:0] xcls_code(xcls_kind_e k);
    logic [2:0] c;
    case (k)
      CL_EMPTY:  c = 3'b101;
      CL_ZERO:   c = 3'b100;
      CL_DENORM: c = 3'b110;
      CL_NORMAL: c = 3'b010;
      CL_INF:    c = 3'b011;
      CL_NAN:    c = 3'b001;
      default:   c = 3'b000;
    endcase
    return c;
  endfunction

  // flags to class, with empty taking precedence
  function automatic xcls_kind_e xcls_pick(xcls_flags_t f);
    xcls_kind_e k;
    if (f.empty)       k = CL_EMPTY;
    else if (f.zero)   k = CL_ZERO;
    else if (f.denorm) k = CL_DENORM;
    else if (f.normal) k = CL_NORMAL;
    else if (f.inf)    k = CL_INF;
    else if (f.nan)    k = CL_NAN;
    else               k = CL_UNSUP;
    return k;
  endfunction

endpackage

// File: rtl/xcls_fields.sv
module xcls_fields
  import xcls_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  localparam int VAL_W = 1 + EXP_W + SIG_W
) (
  input  logic             empty_i,
  input  logic [VAL_W-1:0] value_i,
  output xcls_flags_t      flags_o,
  output logic             sign_o
);

  logic [EXP_W-1:0] exp_f;
  logic [SIG_W-1:0] sig_f;
  logic             int_bit;
  logic             exp_zero, exp_max, sig_zero, frac_zero;

  assign exp_f     = value_i[SIG_W +: EXP_W];
  assign sig_f     = value_i[SIG_W-1:0];
  assign int_bit   = sig_f[SIG_W-1];
  assign exp_zero  = (exp_f == '0);
  assign exp_max   = (exp_f == '1);
  assign sig_zero  = (sig_f == '0);
  assign frac_zero = (sig_f[SIG_W-2:0] == '0);
  assign sign_o    = value_i[VAL_W-1];

  always_comb begin
    flags_o        = '0;
    flags_o.empty  = empty_i;
    flags_o.zero   = !empty_i && exp_zero && sig_zero;
    flags_o.denorm = !empty_i && exp_zero && !sig_zero;
    flags_o.normal = !empty_i && !exp_zero && !exp_max && int_bit;
    flags_o.inf    = !empty_i && exp_max && int_bit && frac_zero;
    flags_o.nan    = !empty_i && exp_max && int_bit && !frac_zero;
    flags_o.unsup  = !empty_i && !exp_zero && !int_bit;
  end

  // R4 R5 R6 R7 R8 R9: the class decodes are disjoint and complete
  always_comb begin
    if (!$isunknown(value_i) && !$isunknown(empty_i)) begin
      flags_onehot_chk: assert ($countones(flags_o) == 1);
    end
  end

endmodule

// File: rtl/xcls_codec.sv
module xcls_codec
  import xcls_pkg::*;
(
  input  xcls_flags_t flags_i,
  input  logic        sign_i,
  output xcls_kind_e  kind_o,
  output logic [3:0]  cc_o
);

  logic [2:0] c320;

  assign kind_o = xcls_pick(flags_i);
  assign c320   = xcls_code(kind_o);
  assign cc_o   = {c320[2], c320[1], sign_i, c320[0]};

endmodule

// File: rtl/xcls_top.sv
module xcls_top
  import xcls_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  localparam int VAL_W = 1 + EXP_W + SIG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             empty_i,
  input  logic [VAL_W-1:0] value_i,
  output logic             valid_o,
  output logic [3:0]       cc_o
);

  xcls_flags_t flags_w;
  logic        sign_w;
  xcls_kind_e  kind_w;
  logic [3:0]  cc_next_w;
  logic [3:0]  cc_q;
  logic        valid_q;

  xcls_fields #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_fields (
    .empty_i (empty_i),
    .value_i (value_i),
    .flags_o (flags_w),
    .sign_o  (sign_w)
  );

  xcls_codec u_codec (
    .flags_i (flags_w),
    .sign_i  (sign_w),
    .kind_o  (kind_w),
    .cc_o    (cc_next_w)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cc_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= start_i;
      if (start_i) cc_q <= cc_next_w;
    end
  end

  assign valid_o = valid_q;
  assign cc_o    = cc_q;

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  // R2
  valid_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  // R2
  cc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(cc_o));
  // R10
  sign_c1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cc_o[1] == $past(value_i[VAL_W-1])));
  // R3
  empty_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && empty_i) |=> (cc_o[3] && !cc_o[2] && cc_o[0]));
  // R7
  inf_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && kind_w == CL_INF) |=> (cc_o[3:2] == 2'b01 && cc_o[0]));

endmodule

// File: tb/tb_xcls_top.sv
`timescale 1ns/1ps
module tb_xcls_top;

  localparam int NV = 14;
  // row: {empty, exponent[14:0], significand[63:0], {C3,C2,C0}, tag}
  localparam logic [86:0] TAB [NV] = '{
    {1'b0, 15'h0000, 64'h0000_0000_0000_0000, 3'b100, 4'd4},
    {1'b0, 15'h0000, 64'h0000_0000_0000_0001, 3'b110, 4'd5},
    {1'b0, 15'h0000, 64'h8000_0000_0000_0000, 3'b110, 4'd5},
    {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000, 3'b010, 4'd6},
    {1'b0, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF, 3'b010, 4'd6},
    {1'b0, 15'h0001, 64'h8000_0000_0000_0000, 3'b010, 4'd6},
    {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000, 3'b011, 4'd7},
    {1'b0, 15'h7FFF, 64'hC000_0000_0000_0000, 3'b001, 4'd8},
    {1'b0, 15'h7FFF, 64'h8000_0000_0000_0001, 3'b001, 4'd8},
    {1'b0, 15'h7FFF, 64'h4000_0000_0000_0000, 3'b000, 4'd9},
    {1'b0, 15'h7FFF, 64'h0000_0000_0000_0000, 3'b000, 4'd9},
    {1'b0, 15'h3FFF, 64'h7FFF_FFFF_FFFF_FFFF, 3'b000, 4'd9},
    {1'b1, 15'h0000, 64'h0000_0000_0000_0000, 3'b101, 4'd3},
    {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000, 3'b101, 4'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        empty = 1'b0;
  logic [79:0] value = '0;
  logic        valid;
  logic [3:0]  cc;
  int          total = 0;
  int          bad = 0;

  always #10 clk = ~clk;

  xcls_top dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .empty_i (empty),
    .value_i (value),
    .valid_o (valid),
    .cc_o    (cc)
  );

  function automatic string tag_name(logic [3:0] t);
    case (t)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got valid/cc=%b expected %b", req, act, exp);
    end
  endtask

  // present one value, then sample at the next falling edge (one register)
  task automatic run1(logic e, logic [79:0] v);
    @(negedge clk);
    start = 1'b1; empty = e; value = v;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", {valid, cc}, 5'b0_0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {valid, cc}, 5'b0_0000);

    // table sweep, each row with both signs; C1 follows the sign (R10)
    for (int i = 0; i < NV; i++) begin
      for (int s = 0; s < 2; s++) begin
        logic [2:0] c;
        c = TAB[i][6:4];
        run1(TAB[i][86], {s[0], TAB[i][85:7]});
        chk(tag_name(TAB[i][3:0]), {valid, cc}, {1'b1, c[2], c[1], s[0], c[0]});
        chk("R10", {4'b0, cc[1]}, {4'b0, s[0]});
      end
    end

    // R2: result holds and valid stays low while inputs wander without a strobe
    run1(1'b0, {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000});
    chk("R7", {valid, cc}, 5'b1_0111);
    for (int k = 0; k < 3; k++) begin
      empty = k[0];
      value = {1'b0, 15'h0000, 64'h0000_0000_0000_0000};
      @(negedge clk);
      chk("R2", {valid, cc}, 5'b0_0111);
    end

    // R2: back-to-back strobes give one result per cycle
    @(negedge clk);
    start = 1'b1; empty = 1'b0; value = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
    @(negedge clk);
    chk("R2", {valid, cc}, 5'b1_0100);
    value = {1'b1, 15'h0000, 64'h0000_0000_0000_0000};
    @(negedge clk);
    chk("R2", {valid, cc}, 5'b1_1010);
    start = 1'b0;
    @(negedge clk);
    chk("R2", {valid, cc}, 5'b0_1010);

    // R1: reset clears a held result
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", {valid, cc}, 5'b0_0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {valid, cc}, 5'b0_0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule